// File: doc/BRIEF.md
# Manchester Bit-Stream Receiver

This block turns a Manchester-coded serial line back into data words. A zero symbol is a high half-period followed by a low half-period. A one symbol is low then high. Every bit has a transition in its middle, and the receiver re-aligns its bit timing to each of these transitions. It then waits three quarters of a bit and looks at the line. That level tells it which transition to expect next. High means the next bit is a zero, which will fall at mid-bit. Low means a one, which will rise at mid-bit.

All timing counts pulses of `tick_en`, with twelve ticks per bit by default. The line rests low when nothing is sent, and every burst begins with a zero bit. While armed, the receiver waits for the line to go high. It then pauses for a short fixed number of ticks and starts looking for mid-bit edges.

Recovered bits are packed least-significant first into 32-bit words. Each full word is offered on a valid/ready output. If a word completes while the previous one is still waiting, the new word is lost and a sticky flag is raised. If the expected mid-bit edge does not arrive, the receiver gives up and re-arms. Dropping `enable` also re-arms it. In both cases the partial word is discarded.

Top module: `manch_rx`

The receiver states are:
- `RX_ARMED`: waiting for a high level.
- `RX_PAUSE`: the start-up delay.
- `RX_SEEK_FALL`: a zero is expected, so it waits for a low level.
- `RX_SEEK_RISE`: a one is expected, so it waits for a high level.
- `RX_SETTLE`: the post-bit wait that ends in the decision sample.

The transitions between them are:
- arm-detect: `RX_ARMED` to `RX_PAUSE`
- pause-done: `RX_PAUSE` to `RX_SEEK_FALL`
- record-0: `RX_SEEK_FALL` to `RX_SETTLE`
- record-1: `RX_SEEK_RISE` to `RX_SETTLE`
- decide-0: `RX_SETTLE` to `RX_SEEK_FALL`
- decide-1: `RX_SETTLE` to `RX_SEEK_RISE`
- give-up: either seek state to `RX_ARMED`
- disable: any state to `RX_ARMED`

## Requirements
- R1: After reset, `word_valid` and `overflow` are 0.
- R2: While armed and the line stays low, no word is produced, however long the line rests.
- R3: A bit is decoded from its mid-bit transition. A fall decodes as 0 (high half first) and a rise decodes as 1 (low half first). Bits are 12 ticks long and each half is 6 ticks. The kind of the next bit is decided from the line level 9 ticks after the current bit is recorded.
- R4: The leading 0 of a burst is the first recorded bit. Bits fill a word from bit 0 upward, so the k-th received bit lands in bit k-1. A word is emitted after every 32 bits.
- R5: A presented word keeps `word_valid` high and `word_data` unchanged until `word_ready` is seen high. Consecutive words of one burst are all delivered in order.
- R6: A word that completes while an earlier word is still unaccepted is dropped. The held word is unchanged, and `overflow` goes to 1 and stays at 1 until reset.
- R7: If the expected mid-bit level does not appear within 24 ticks, the partial word is discarded and the receiver re-arms. The next burst, which starts with its own leading 0, is decoded from its first bit.
- R8: While `enable` is low, the receiver is held armed and the partial word is cleared. After `enable` returns high, a new burst decodes from its first bit.
- R9: All waits count `tick_en` pulses only. Decoding is correct with ticks on every clock, on every third clock, or at random clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Receiver enable; low clears and re-arms |
| tick_en | input | 1 | Timing tick; 12 per bit period |
| line_in | input | 1 | Asynchronous Manchester line, idle low |
| word_data | output | 32 | Recovered word, first bit in bit 0 |
| word_valid | output | 1 | Word available |
| word_ready | input | 1 | Consumer accepts the word |
| overflow | output | 1 | Sticky word-lost flag |

## Verification
Several fixed words are sent, including all-zero, alternating and all-ones after the leading zero. Together they exercise both decision outcomes, long runs of one kind and each transition path. Random words are sent with ticks on every clock, every third clock and random clocks; these show whether the waits count ticks rather than clocks. A two-word burst is sent twice: once with ready held low, which separates a correct drop-and-flag from an overwrite, and once with random ready, which checks in-order delivery. Truncated bursts, ended either by silence or by disabling, show whether stale partial bits leak into the next word.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

    typedef enum logic [2:0] {
        RX_ARMED,
        RX_PAUSE,
        RX_SEEK_FALL,
        RX_SEEK_RISE,
        RX_SETTLE
    } rx_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/manch_sync.sv
module manch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/manch_track.sv
module manch_track
    import manch_rx_pkg::*;
#(
    parameter int BIT_TICKS = 12,
    parameter int ARM_PAUSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick_en,
    input  logic line,
    output logic bit_stb,
    output logic bit_val,
    output logic flush
);
    localparam int SAMPLE_WAIT = (BIT_TICKS * 3) / 4;
    localparam int TIMEOUT     = 2 * BIT_TICKS;
    localparam int CNT_MAX     = max3(SAMPLE_WAIT, TIMEOUT, ARM_PAUSE);
    localparam int CW          = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PAUSE_LAST  = CW'(ARM_PAUSE - 1);
    localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_WAIT - 1);
    localparam logic [CW-1:0] TMO_LAST    = CW'(TIMEOUT - 1);

    rx_state_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic rec, rec_v, drop;

    // next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        rec    = 1'b0;
        rec_v  = 1'b0;
        drop   = 1'b0;
        if (!enable) begin
            st_nx  = RX_ARMED;
            cnt_nx = '0;
            drop   = 1'b1;
        end else if (tick_en) begin
            unique case (st)
                RX_ARMED: begin
                    if (line) begin
                        st_nx  = RX_PAUSE;
                        cnt_nx = '0;
                    end
                end
                RX_PAUSE: begin
                    if (cnt == PAUSE_LAST) begin
                        st_nx  = RX_SEEK_FALL;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                RX_SEEK_FALL: begin
                    if (!line) begin
                        rec    = 1'b1;
                        rec_v  = 1'b0;
                        st_nx  = RX_SETTLE;
                        cnt_nx = '0;
                    end else if (cnt == TMO_LAST) begin
                        drop   = 1'b1;
                        st_nx  = RX_ARMED;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                RX_SEEK_RISE: begin
                    if (line) begin
                        rec    = 1'b1;
                        rec_v  = 1'b1;
                        st_nx  = RX_SETTLE;
                        cnt_nx = '0;
                    end else if (cnt == TMO_LAST) begin
                        drop   = 1'b1;
                        st_nx  = RX_ARMED;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                RX_SETTLE: begin
                    if (cnt == SAMPLE_LAST) begin
                        st_nx  = line ? RX_SEEK_FALL : RX_SEEK_RISE;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                default: begin
                    st_nx  = RX_ARMED;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= RX_ARMED;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
            flush   <= 1'b0;
        end else begin
            bit_stb <= rec;
            bit_val <= rec_v;
            flush   <= drop;
        end
    end

    p_disable_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st == RX_ARMED && flush));
    p_strobe_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> ($past(tick_en) && $past(enable)));
    p_seek_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_SEEK_FALL || st == RX_SEEK_RISE) |-> (cnt <= TMO_LAST));
    p_record_from_seek_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> ($past(st) == RX_SEEK_FALL || $past(st) == RX_SEEK_RISE));
endmodule

// File: rtl/manch_pack.sv
module manch_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              flush,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic              overflow
);
    localparam int FW = $clog2(WORD_W);
    localparam logic [FW-1:0] FILL_LAST = FW'(WORD_W - 1);

    logic [WORD_W-1:0] sreg;
    logic [FW-1:0]     fill;
    logic [WORD_W-1:0] sreg_nx;
    logic              done;

    assign sreg_nx = {bit_val, sreg[WORD_W-1:1]};
    assign done    = bit_stb && (fill == FILL_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            fill <= '0;
        end else if (flush) begin
            fill <= '0;
        end else if (bit_stb) begin
            sreg <= sreg_nx;
            fill <= done ? '0 : fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_data  <= '0;
            word_valid <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            if (word_valid && word_ready) word_valid <= 1'b0;
            if (done) begin
                if (word_valid && !word_ready) begin
                    overflow <= 1'b1;
                end else begin
                    word_data  <= sreg_nx;
                    word_valid <= 1'b1;
                end
            end
        end
    end

    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
    p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    p_overflow_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (word_valid && $stable(word_data)));
    p_no_mix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_stb && flush));
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
    parameter int WORD_W      = 32,
    parameter int BIT_TICKS   = 12,
    parameter int ARM_PAUSE   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick_en,
    input  logic              line_in,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic              overflow
);
    logic line_s;
    logic bit_stb, bit_val, flush;

    manch_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_in),
        .q_sync  (line_s)
    );

    manch_track #(.BIT_TICKS(BIT_TICKS), .ARM_PAUSE(ARM_PAUSE)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick_en (tick_en),
        .line    (line_s),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .flush   (flush)
    );

    manch_pack #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .flush      (flush),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .overflow   (overflow)
    );
endmodule

// File: tb/manch_rx_bench.sv
`timescale 1ns/1ps
module manch_rx_bench;
    logic clk = 1'b0;
    logic rst_n, enable, tick_en, line_in, word_ready;
    logic [31:0] word_data;
    logic word_valid, overflow;

    always #4 clk = ~clk;

    manch_rx u_manch_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_en(tick_en),
        .line_in(line_in), .word_data(word_data), .word_valid(word_valid),
        .word_ready(word_ready), .overflow(overflow)
    );

    int gap;        // 0 = random ticks, else tick every gap clocks
    int gcnt;
    int rdy_mode;   // 0 always, 1 random, 2 never
    logic [31:0] got [0:63];
    int got_n;
    int checks, errors;
    bit done;

    function automatic logic [31:0] lead0(input logic [31:0] w);
        return w & 32'hFFFF_FFFE;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (gap == 0) tick_en = ($urandom_range(0, 1) == 1);
        else begin
            tick_en = (gcnt == 0);
            gcnt = (gcnt + 1 >= gap) ? 0 : gcnt + 1;
        end
        case (rdy_mode)
            0: word_ready = 1'b1;
            1: word_ready = ($urandom_range(0, 3) != 0);
            default: word_ready = 1'b0;
        endcase
        if (word_valid && word_ready && got_n < 64) begin
            got[got_n] = word_data;
            got_n++;
        end
    endtask

    task automatic ticks(input int n);
        int k = 0;
        while (k < n) begin
            step();
            if (tick_en) k++;
        end
    endtask

    task automatic send_bit(input logic b);
        line_in = b ? 1'b0 : 1'b1;
        ticks(6);
        line_in = b ? 1'b1 : 1'b0;
        ticks(6);
    endtask

    task automatic send_word(input logic [31:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(w[i]);
    endtask

    task automatic idle(input int n);
        line_in = 1'b0;
        ticks(n);
    endtask

    task automatic expect_words(input string req, input int n,
                                input logic [31:0] e0, input logic [31:0] e1);
        chk(got_n == n, req, "word count", 32'(got_n), 32'(n));
        if (n > 0 && got_n > 0) chk(got[0] == e0, req, "word 0", got[0], e0);
        if (n > 1 && got_n > 1) chk(got[1] == e1, req, "word 1", got[1], e1);
        got_n = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, w2;
        void'($urandom(32'd7315));
        done = 0; checks = 0; errors = 0; got_n = 0;
        gap = 1; gcnt = 0; rdy_mode = 0;
        enable = 1'b1; tick_en = 1'b0; line_in = 1'b0; word_ready = 1'b1;
        do_reset();
        // R1 reset state
        chk(word_valid == 1'b0, "R1", "valid after reset", 32'(word_valid), 0);
        chk(overflow == 1'b0, "R1", "overflow after reset", 32'(overflow), 0);

        // R2 idle low line yields nothing
        idle(100);
        expect_words("R2", 0, 0, 0);
        chk(word_valid == 1'b0, "R2", "valid while idle", 32'(word_valid), 0);

        // R3 / R4 directed patterns
        w = 32'hA5F0_3C96; send_word(w, 32); idle(40); expect_words("R4", 1, w, 0);
        w = 32'h0000_0000; send_word(w, 32); idle(40); expect_words("R3", 1, w, 0);
        w = 32'hFFFF_FFFE; send_word(w, 32); idle(40); expect_words("R3", 1, w, 0);
        w = 32'h5555_5554; send_word(w, 32); idle(40); expect_words("R3", 1, w, 0);

        // R9 random words with different tick spacings
        for (int r = 0; r < 6; r++) begin
            gap = (r % 3 == 0) ? 1 : ((r % 3 == 1) ? 3 : 0);
            gcnt = 0;
            w = lead0($urandom);
            send_word(w, 32); idle(40);
            expect_words("R9", 1, w, 0);
        end
        gap = 1;

        // R5 two back-to-back words with random ready
        rdy_mode = 1;
        w = lead0($urandom); w2 = $urandom;
        send_word(w, 32); send_word(w2, 32); idle(40);
        ticks(10);
        expect_words("R5", 2, w, w2);
        rdy_mode = 0;

        // R6 overflow: ready held low across two words
        rdy_mode = 2;
        w = lead0($urandom); w2 = $urandom;
        send_word(w, 32); send_word(w2, 32); idle(40);
        chk(word_valid == 1'b1, "R6", "held valid", 32'(word_valid), 1);
        chk(word_data == w, "R6", "held data", word_data, w);
        chk(overflow == 1'b1, "R6", "overflow set", 32'(overflow), 1);
        rdy_mode = 0;
        ticks(5);
        expect_words("R6", 1, w, 0);
        chk(overflow == 1'b1, "R6", "overflow sticky", 32'(overflow), 1);
        chk(word_valid == 1'b0, "R5", "valid cleared by ready", 32'(word_valid), 0);
        do_reset();
        chk(overflow == 1'b0, "R1", "overflow cleared by reset", 32'(overflow), 0);

        // R7 truncated burst then silence
        w = lead0($urandom);
        send_word(w, 20); idle(40);
        expect_words("R7", 0, 0, 0);
        w = lead0($urandom);
        send_word(w, 32); idle(40);
        expect_words("R7", 1, w, 0);

        // R8 disable mid-burst
        w = lead0($urandom);
        send_word(w, 20);
        line_in = 1'b0;
        enable = 1'b0;
        ticks(8);
        enable = 1'b1;
        idle(4);
        expect_words("R8", 0, 0, 0);
        w = lead0($urandom);
        send_word(w, 32); idle(40);
        expect_words("R8", 1, w, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule